// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a small 32-bit RISC core. A program names one of sixteen logical registers with a 4-bit index. The physical storage behind that index depends on a 5-bit processor-mode input. Some modes get private copies of the stack pointer (index 13) and link register (index 14). The fast-interrupt mode also gets private copies of indices 8 to 12. The remaining registers are shared by all modes. Index 15 is the program counter, which every mode shares. Whatever is written there is stored with its low bits cleared according to the current instruction-state bit.

The block also holds one current status word. It holds one saved status word for each of the five exception modes. Software reaches the saved status word of the current mode through a dedicated port. An exception-entry strobe copies the current status word into the saved slot of a named target mode. User mode, system mode and any unrecognised mode code have no saved slot of their own. In those modes the saved-status port is redirected onto the current status word.

There are two combinational read ports and one write port. Writes take effect at the rising clock edge. All pins are plain control and data pins. There is no handshake, because every access completes in the cycle it is presented.

Top module: `banked_regfile`

## Requirements
- R1: While and after an active-low reset, every general register and the program counter read as zero, every saved status word is zero, and the current status word is 32'h0000_00D3. That value means mode bits [4:0]=10011, the IRQ-disable bit 7 set, the FIQ-disable bit 6 set and the state bit 5 clear.
- R2: Logical indices 0 to 7 map to the same storage in every mode.
- R3: Indices 8 to 12 have a private copy in fast-interrupt mode (10001). Every other mode shares one common copy.
- R4: Indices 13 and 14 have a private copy in each of the modes 10001, 10010, 10011, 10111 and 11011. Modes 10000 and 11111 and every other code share the common copy.
- R5: Index 15 is the program counter, which all modes share. A write stores the data with bits [1:0] cleared when status bit 5 is 0, and with bit 0 cleared when status bit 5 is 1. A write to any other index leaves the program counter unchanged.
- R6: Both read ports return the addressed register in the same cycle. A write becomes visible from the cycle after its clock edge, so a read in the same cycle as a write returns the old value.
- R7: A status write loads the whole 32-bit word at the next edge. The fields are N, Z, C and V in bits 31 to 28, I in bit 7, F in bit 6, T in bit 5 and the mode in bits 4 to 0. Of these fields, the block itself acts only on T.
- R8: In the five exception modes, the saved-status port reads and writes the slot of the current mode. In any other mode, a read returns the current status word and a write loads it. If a status write occurs in the same cycle, the status write wins.
- R9: An exception-save strobe copies the current status word, as it stood before the edge, into the saved slot of the target mode. If the target mode has no slot, the strobe has no effect. If a saved-status write targets the same slot in the same cycle, the strobe wins.
- R10: A link write to index 14 changes only the index-14 register of the mode that is current in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| rda_idx_i | input | 4 | Read port A logical index |
| rda_data_o | output | 32 | Read port A data |
| rdb_idx_i | input | 4 | Read port B logical index |
| rdb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Register write logical index |
| wr_data_i | input | 32 | Register write data |
| stat_we_i | input | 1 | Current status write enable |
| stat_wdata_i | input | 32 | Current status write data |
| stat_o | output | 32 | Current status word |
| saved_we_i | input | 1 | Saved status write enable (current mode) |
| saved_wdata_i | input | 32 | Saved status write data |
| saved_o | output | 32 | Saved status word of current mode, or current status |
| exc_save_i | input | 1 | Exception entry: copy status into target slot |
| exc_mode_i | input | 5 | Target mode of the exception save |

## Verification
Random cycles mix the seven defined mode codes with one unassigned code. They also combine register writes, saved-status writes, status writes and exception saves in the same cycle. This separates a wrong bank choice (R2 to R4, R10) from a wrong write priority (R8, R9). Directed steps address the same index in several modes after a single write, which exposes any aliasing between banks. They write the program counter with the state bit clear and then set, which tells the two alignment masks apart. They also read during a write, which catches a bypass that should not exist. Saves aimed at user mode and at an unassigned code show whether the missing slot is ignored or wrongly aliased.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int XLEN     = 32;
  localparam int NLOG     = 16;
  localparam int IDXW     = $clog2(NLOG);
  localparam int MODEW    = 5;
  localparam int NSHARED  = 15;            // common copy of indices 0..14
  localparam int FIQ_LO   = 8;             // first index banked in fast-interrupt mode
  localparam int NFIQ     = 7;             // fast-interrupt private indices 8..14
  localparam int NEXC2    = 4;             // modes banking only 13 and 14
  localparam int NPHYS    = NSHARED + NFIQ + 2 * NEXC2;
  localparam int PHYSW    = $clog2(NPHYS);
  localparam int NSAVED   = 5;
  localparam int SLOTW    = $clog2(NSAVED);
  localparam int PC_IDX   = NLOG - 1;
  localparam int SP_IDX   = 13;
  localparam int T_BIT    = 5;
  localparam logic [XLEN-1:0] STAT_RESET = 32'h0000_00D3;

  typedef logic [MODEW-1:0] mode_t;
  localparam mode_t MD_USR = 5'b10000;
  localparam mode_t MD_FIQ = 5'b10001;
  localparam mode_t MD_IRQ = 5'b10010;
  localparam mode_t MD_SVC = 5'b10011;
  localparam mode_t MD_ABT = 5'b10111;
  localparam mode_t MD_UND = 5'b11011;
  localparam mode_t MD_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BANK_COMMON = 3'd0,
    BANK_FIQ    = 3'd1,
    BANK_IRQ    = 3'd2,
    BANK_SVC    = 3'd3,
    BANK_ABT    = 3'd4,
    BANK_UND    = 3'd5
  } bank_e;

  function automatic bank_e bank_of(mode_t m);
    case (m)
      MD_FIQ:  return BANK_FIQ;
      MD_IRQ:  return BANK_IRQ;
      MD_SVC:  return BANK_SVC;
      MD_ABT:  return BANK_ABT;
      MD_UND:  return BANK_UND;
      default: return BANK_COMMON;
    endcase
  endfunction

  function automatic logic [SLOTW-1:0] slot_of(bank_e b);
    return SLOTW'(int'(b) - 1);
  endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  mode_t             mode_i,
  input  logic [IDXW-1:0]   idx_i,
  output logic [PHYSW-1:0]  phys_o,
  output logic              is_pc_o
);
  bank_e bank;
  int    idx_n;
  int    phys_n;

  always_comb begin
    bank   = bank_of(mode_i);
    idx_n  = int'(idx_i);
    phys_n = idx_n;
    if (bank == BANK_FIQ && idx_n >= FIQ_LO && idx_n < PC_IDX) begin
      phys_n = NSHARED + idx_n - FIQ_LO;
    end else if (bank != BANK_COMMON && bank != BANK_FIQ && idx_n >= SP_IDX && idx_n < PC_IDX) begin
      phys_n = NSHARED + NFIQ + 2 * (int'(bank) - int'(BANK_IRQ)) + (idx_n - SP_IDX);
    end
    phys_o  = PHYSW'(phys_n);
    is_pc_o = (idx_n == PC_IDX);
  end
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr
  import bankreg_pkg::*;
#(
  parameter int NRD = 2
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][PHYSW-1:0]  rd_phys_i,
  input  logic [NRD-1:0]             rd_pc_i,
  output logic [NRD-1:0][XLEN-1:0]   rd_data_o,
  input  logic                       wr_en_i,
  input  logic [PHYSW-1:0]           wr_phys_i,
  input  logic                       wr_pc_i,
  input  logic [XLEN-1:0]            wr_data_i,
  input  logic                       t_state_i
);
  logic [XLEN-1:0] regs_q [NPHYS];
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;

  always_comb begin
    pc_next = wr_data_i;
    pc_next[0] = 1'b0;
    if (!t_state_i) pc_next[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      for (int i = 0; i < NPHYS; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      if (wr_pc_i) pc_q <= pc_next;
      else         regs_q[wr_phys_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = rd_pc_i[p] ? pc_q : regs_q[rd_phys_i[p]];
  end

  assert_pc_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_pc_i && !t_state_i) |=> (pc_q[1:0] == 2'b00));

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en_i && wr_pc_i)) |=> $stable(pc_q));
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_i,
  input  logic             stat_we_i,
  input  logic [XLEN-1:0]  stat_wdata_i,
  output logic [XLEN-1:0]  stat_o,
  input  logic             saved_we_i,
  input  logic [XLEN-1:0]  saved_wdata_i,
  output logic [XLEN-1:0]  saved_o,
  input  logic             exc_save_i,
  input  mode_t            exc_mode_i,
  output logic             t_state_o
);
  logic [XLEN-1:0]  stat_q;
  logic [XLEN-1:0]  saved_q [NSAVED];
  bank_e            cur_bank, exc_bank;
  logic             cur_has_slot, exc_has_slot;
  logic [SLOTW-1:0] cur_slot, exc_slot;

  always_comb begin
    cur_bank     = bank_of(mode_i);
    exc_bank     = bank_of(exc_mode_i);
    cur_has_slot = (cur_bank != BANK_COMMON);
    exc_has_slot = (exc_bank != BANK_COMMON);
    cur_slot     = slot_of(cur_bank);
    exc_slot     = slot_of(exc_bank);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
      for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
    end else begin
      if (stat_we_i)
        stat_q <= stat_wdata_i;
      else if (saved_we_i && !cur_has_slot)
        stat_q <= saved_wdata_i;
      for (int i = 0; i < NSAVED; i++) begin
        if (exc_save_i && exc_has_slot && exc_slot == SLOTW'(i))
          saved_q[i] <= stat_q;
        else if (saved_we_i && cur_has_slot && cur_slot == SLOTW'(i))
          saved_q[i] <= saved_wdata_i;
      end
    end
  end

  assign stat_o    = stat_q;
  assign saved_o   = cur_has_slot ? saved_q[cur_slot] : stat_q;
  assign t_state_o = stat_q[T_BIT];

  assert_stat_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we_i |=> (stat_o == $past(stat_wdata_i)));

  assert_saved_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (saved_we_i && !cur_has_slot && !stat_we_i) |=> (stat_o == $past(saved_wdata_i)));

  assert_exc_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_save_i && exc_has_slot) |=> (saved_q[$past(exc_slot)] == $past(stat_q)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  mode_i,
  input  logic [3:0]  rda_idx_i,
  output logic [31:0] rda_data_o,
  input  logic [3:0]  rdb_idx_i,
  output logic [31:0] rdb_data_o,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_idx_i,
  input  logic [31:0] wr_data_i,
  input  logic        stat_we_i,
  input  logic [31:0] stat_wdata_i,
  output logic [31:0] stat_o,
  input  logic        saved_we_i,
  input  logic [31:0] saved_wdata_i,
  output logic [31:0] saved_o,
  input  logic        exc_save_i,
  input  logic [4:0]  exc_mode_i
);
  localparam int NRD  = 2;
  localparam int NMAP = NRD + 1;   // read ports then the write port

  logic [NMAP-1:0][IDXW-1:0]  map_idx;
  logic [NMAP-1:0][PHYSW-1:0] map_phys;
  logic [NMAP-1:0]            map_pc;
  logic [NRD-1:0][XLEN-1:0]   rd_data;
  logic                       t_state;

  assign map_idx[0] = rda_idx_i;
  assign map_idx[1] = rdb_idx_i;
  assign map_idx[2] = wr_idx_i;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    bankreg_map u_map (
      .mode_i  (mode_i),
      .idx_i   (map_idx[g]),
      .phys_o  (map_phys[g]),
      .is_pc_o (map_pc[g])
    );
  end

  bankreg_gpr #(.NRD(NRD)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_phys_i (map_phys[NRD-1:0]),
    .rd_pc_i   (map_pc[NRD-1:0]),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en_i),
    .wr_phys_i (map_phys[NRD]),
    .wr_pc_i   (map_pc[NRD]),
    .wr_data_i (wr_data_i),
    .t_state_i (t_state)
  );

  bankreg_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .stat_we_i     (stat_we_i),
    .stat_wdata_i  (stat_wdata_i),
    .stat_o        (stat_o),
    .saved_we_i    (saved_we_i),
    .saved_wdata_i (saved_wdata_i),
    .saved_o       (saved_o),
    .exc_save_i    (exc_save_i),
    .exc_mode_i    (exc_mode_i),
    .t_state_o     (t_state)
  );

  assign rda_data_o = rd_data[0];
  assign rdb_data_o = rd_data[1];

  // R2: the low indices never depend on the mode
  assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx[0] < 4'd8) |-> (map_phys[0] == PHYSW'(map_idx[0])));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode, exc_mode;
  logic [3:0]  rda_idx, rdb_idx, wr_idx;
  logic [31:0] rda_data, rdb_data, wr_data, stat_wdata, saved_wdata, stat_q, saved_q;
  logic        wr_en, stat_we, saved_we, exc_save;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_reg [30];
  logic [31:0] m_saved [5];
  logic [31:0] m_pc, m_stat;

  always #5 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rda_idx_i(rda_idx), .rda_data_o(rda_data),
    .rdb_idx_i(rdb_idx), .rdb_data_o(rdb_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .stat_o(stat_q),
    .saved_we_i(saved_we), .saved_wdata_i(saved_wdata), .saved_o(saved_q),
    .exc_save_i(exc_save), .exc_mode_i(exc_mode)
  );

  function automatic int m_phys(logic [4:0] md, int r);
    case (md)
      5'b10001: if (r >= 8 && r <= 14) return 15 + (r - 8);
      5'b10010: if (r == 13 || r == 14) return 22 + (r - 13);
      5'b10011: if (r == 13 || r == 14) return 24 + (r - 13);
      5'b10111: if (r == 13 || r == 14) return 26 + (r - 13);
      5'b11011: if (r == 13 || r == 14) return 28 + (r - 13);
      default: ;
    endcase
    return r;
  endfunction

  function automatic int m_slot(logic [4:0] md);
    case (md)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic string req_of(int r);
    if (r < 8)   return "R2";
    if (r < 13)  return "R3";
    if (r == 13) return "R4";
    if (r == 14) return "R10";
    return "R5";
  endfunction

  function automatic logic [31:0] m_read(int r);
    return (r == 15) ? m_pc : m_reg[m_phys(mode, r)];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    int s;
    chk(req_of(int'(rda_idx)), "port A", rda_data, m_read(int'(rda_idx)));
    chk(req_of(int'(rdb_idx)), "port B", rdb_data, m_read(int'(rdb_idx)));
    chk("R7", "status", stat_q, m_stat);
    s = m_slot(mode);
    chk("R8", "saved", saved_q, (s >= 0) ? m_saved[s] : m_stat);
  endtask

  task automatic model_update();
    logic [31:0] old_stat = m_stat;
    int cs = m_slot(mode);
    int es = m_slot(exc_mode);
    if (wr_en) begin
      if (wr_idx == 4'd15) m_pc = old_stat[5] ? {wr_data[31:1], 1'b0} : {wr_data[31:2], 2'b00};
      else m_reg[m_phys(mode, int'(wr_idx))] = wr_data;
    end
    if (saved_we && cs >= 0 && !(exc_save && es == cs)) m_saved[cs] = saved_wdata;
    if (exc_save && es >= 0) m_saved[es] = old_stat;
    if (stat_we) m_stat = stat_wdata;
    else if (saved_we && cs < 0) m_stat = saved_wdata;
  endtask

  task automatic idle();
    wr_en = 0; stat_we = 0; saved_we = 0; exc_save = 0;
    wr_idx = 0; wr_data = 0; stat_wdata = 0; saved_wdata = 0; exc_mode = 5'b10000;
  endtask

  // called at a negative edge with inputs already driven
  task automatic cycle();
    #1 check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic peek(logic [4:0] md, logic [3:0] r, string req, logic [31:0] exp);
    idle(); mode = md; rda_idx = r; rdb_idx = r;
    #1 chk(req, "directed read", rda_data, exp);
    @(negedge clk);
  endtask

  function automatic logic [4:0] pick_mode(int k);
    case (k % 8)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010; 3: return 5'b10011;
      4: return 5'b10111; 5: return 5'b11011; 6: return 5'b11111; default: return 5'b00110;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; idle(); mode = 5'b10011; rda_idx = 0; rdb_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 30; i++) m_reg[i] = '0;
    for (int i = 0; i < 5; i++) m_saved[i] = '0;
    m_pc = '0; m_stat = 32'h0000_00D3;

    // R1 reset state
    #1 chk("R1", "reset status", stat_q, 32'h0000_00D3);
    chk("R1", "reset saved", saved_q, 32'h0);
    @(negedge clk);
    peek(5'b10000, 4'd15, "R1", 32'h0);
    peek(5'b10001, 4'd14, "R1", 32'h0);

    // R6 read during write returns the old value, new value next cycle
    idle(); mode = 5'b10000; wr_en = 1; wr_idx = 4'd3; wr_data = 32'hAAAA_5555;
    rda_idx = 4'd3; rdb_idx = 4'd3;
    #1 chk("R6", "same-cycle read", rda_data, 32'h0);
    @(posedge clk); model_update(); @(negedge clk);
    peek(5'b10001, 4'd3, "R6", 32'hAAAA_5555);
    peek(5'b11011, 4'd3, "R2", 32'hAAAA_5555);

    // R10 link write lands only in the current mode's index 14
    idle(); mode = 5'b10010; wr_en = 1; wr_idx = 4'd14; wr_data = 32'h0000_1234;
    rda_idx = 0; rdb_idx = 0; cycle();
    peek(5'b10010, 4'd14, "R10", 32'h0000_1234);
    peek(5'b10011, 4'd14, "R10", 32'h0);
    peek(5'b11111, 4'd14, "R4", 32'h0);

    // R3 fast-interrupt private copy of index 10
    idle(); mode = 5'b10001; wr_en = 1; wr_idx = 4'd10; wr_data = 32'hF1F1_0A0A; cycle();
    peek(5'b10000, 4'd10, "R3", 32'h0);
    peek(5'b10001, 4'd10, "R3", 32'hF1F1_0A0A);

    // R5 program counter alignment under both state values
    idle(); mode = 5'b10000; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h1234_5677; cycle();
    peek(5'b10111, 4'd15, "R5", 32'h1234_5674);
    idle(); stat_we = 1; stat_wdata = 32'h0000_00F3; cycle();
    idle(); wr_en = 1; wr_idx = 4'd15; wr_data = 32'h1234_5677; cycle();
    peek(5'b10000, 4'd15, "R5", 32'h1234_5676);

    // R9 save aimed at modes with no slot is ignored; save wins over saved write
    idle(); mode = 5'b10000; exc_save = 1; exc_mode = 5'b10000; cycle();
    idle(); exc_save = 1; exc_mode = 5'b00110; cycle();
    peek(5'b10000, 4'd0, "R9", 32'hAAAA_5555 & 32'h0);
    idle(); mode = 5'b10011; exc_save = 1; exc_mode = 5'b10011;
    saved_we = 1; saved_wdata = 32'hDEAD_BEEF; cycle();
    idle(); mode = 5'b10011; #1 chk("R9", "save priority", saved_q, 32'h0000_00F3);
    @(negedge clk);

    // R8 saved write in system mode loads the status word
    idle(); mode = 5'b11111; saved_we = 1; saved_wdata = 32'h6000_001F; cycle();
    idle(); #1 chk("R8", "fallback status", stat_q, 32'h6000_001F);
    @(negedge clk);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      mode        = pick_mode(int'($urandom_range(0, 7)));
      rda_idx     = 4'($urandom_range(0, 15));
      rdb_idx     = 4'($urandom_range(0, 15));
      wr_en       = ($urandom_range(0, 1) == 1);
      wr_idx      = 4'($urandom_range(0, 15));
      wr_data     = $urandom;
      stat_we     = ($urandom_range(0, 19) == 0);
      stat_wdata  = {$urandom_range(0, 15) > 0 ? 4'($urandom) : 4'h0, 22'h0, 6'($urandom)};
      saved_we    = ($urandom_range(0, 4) == 0);
      saved_wdata = $urandom;
      exc_save    = ($urandom_range(0, 6) == 0);
      exc_mode    = pick_mode(int'($urandom_range(0, 7)));
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule